// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converters

This block is a purely combinational wide adder. It returns the sum of two operands and a carry-in, plus the carry-out. The operand bits are split into a chain of groups whose widths grow from the least significant end. The lowest group is a plain ripple adder fed by the external carry-in. Every higher group holds one ripple adder that assumes a carry-in of zero. An increment converter, one bit wider than the group, produces that group's carry-in-one result from the zero-carry result, so no second ripple adder is needed. The carry arriving from the group below steers a mux that picks one of the two results.

The operand width is a parameter. Three group tables are supported: 32, 64 and 128 bits. The widths come from a table in the shared package, and elaboration stops if the table does not add up to the chosen width. The block has no clock and no reset. It has no stream handshake, because a result is ready as soon as the operands settle. Registering the inputs or outputs is left to the surrounding logic.

Top module: `sqcsa_adder`

## Requirements
- R1: For every input, `{cout, sum}` equals `a + b + cin` computed to WIDTH+1 bits. With all inputs zero, `sum` and `cout` are zero.
- R2: With WIDTH = 32 (the default), group widths from the least significant end are 2, 2, 3, 4, 6, 7 and 8 bits, so groups begin at bit positions 0, 2, 4, 7, 11, 17 and 24. Any carry that crosses one of these positions gives the correct result.
- R3: With WIDTH = 64, group widths are 2, 2, 3, 4, 6, 7, 8, 9, 11 and 12 bits, so groups begin at bit positions 0, 2, 4, 7, 11, 17, 24, 32, 41 and 52. Any carry that crosses one of these positions gives the correct result.
- R4: Group 0 adds bits 1:0 of both operands together with `cin`. Its carry-out is the select for group 1.
- R5: In each higher group of n bits, an (n+1)-bit converter acts on the zero-carry result `{c, s}`. Output bit 0 is the inverse of input bit 0. Output bit i is input bit i XOR the AND of all lower input bits. The result is the zero-carry value plus one, modulo 2^(n+1).
- R6: In each higher group, an incoming carry of 0 selects the zero-carry ripple result, and an incoming carry of 1 selects the converter output. This applies to both the group sum and the group carry.
- R7: Each group's selected carry-out is the select for the next group. The top group's carry-out is `cout`.
- R8: The group widths sum to WIDTH, which is checked at elaboration. A WIDTH other than 32, 64 or 128 is rejected.
- R9: A carry generated at bit 0 propagates through all groups. With `a` all ones, `b = 0` and `cin = 1`, the result is `sum = 0` and `cout = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench goes after carries that stop exactly at, or run across, each group start for both the 32-bit and 64-bit tables. A design with a wrong table entry, a mis-sliced group or a swapped mux leg would corrupt the bits just above that boundary. A full propagate chain from `cin` to `cout` exposes a converter that drops its extra carry bit, which would leave `cout` low. It would also expose a converter whose AND prefix is short, which would leave stray ones in the sum. Dense random operands at both widths catch select lines wired to the wrong group.

// File: rtl/sqcsa_pkg.sv
package sqcsa_pkg;

  // number of groups in the table for a given total width
  function automatic int grp_count(input int w);
    case (w)
      32:      return 7;
      64:      return 10;
      128:     return 14;
      default: return 1;
    endcase
  endfunction

  // width of group idx; 64 and 128 share a prefix, 32 has its own tail
  function automatic int grp_width(input int w, input int idx);
    if (w == 32) begin
      case (idx)
        0: return 2;
        1: return 2;
        2: return 3;
        3: return 4;
        4: return 6;
        5: return 7;
        6: return 8;
        default: return 0;
      endcase
    end else begin
      case (idx)
        0: return 2;
        1: return 2;
        2: return 3;
        3: return 4;
        4: return 6;
        5: return 7;
        6: return 8;
        7: return 9;
        8: return 11;
        9: return 12;
        10: return 13;
        11: return 14;
        12: return 15;
        13: return 22;
        default: return 0;
      endcase
    end
  endfunction

  // lowest bit position of group idx
  function automatic int grp_offset(input int w, input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += grp_width(w, k);
    return acc;
  endfunction

  // sum of all entries in the table for width w
  function automatic int grp_total(input int w);
    return grp_offset(w, grp_count(w));
  endfunction

endpackage

// File: rtl/sqcsa_rca.sv
module sqcsa_rca #(
  parameter int N = 4
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic         co
);

  logic [N:0] cy;

  assign cy[0] = ci;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign s[i]    = x[i] ^ y[i] ^ cy[i];
    assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
  end

  assign co = cy[N];

  // R4
  always_comb begin
    ripple_sum_chk: assert ({co, s} == ({1'b0, x} + {1'b0, y} + (N+1)'(ci)))
      else $error("ripple adder result mismatch");
  end

endmodule

// File: rtl/sqcsa_inc.sv
module sqcsa_inc #(
  parameter int M = 5
) (
  input  logic [M-1:0] din,
  output logic [M-1:0] dout
);

  logic [M-1:0] pfx;

  assign pfx[0]  = 1'b1;
  assign dout[0] = ~din[0];

  for (genvar i = 1; i < M; i++) begin : g_bit
    assign pfx[i]  = pfx[i-1] & din[i-1];
    assign dout[i] = din[i] ^ pfx[i];
  end

  // R5
  always_comb begin
    excess_one_chk: assert (dout == M'(din + M'(1)))
      else $error("increment converter mismatch");
  end

endmodule

// File: rtl/sqcsa_group.sv
module sqcsa_group #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sel,
  output logic [N-1:0] sum,
  output logic         cout
);

  logic [N-1:0] s0;
  logic         c0;
  logic [N:0]   inc_q;

  sqcsa_rca #(.N(N)) u_rca (
    .x  (a),
    .y  (b),
    .ci (1'b0),
    .s  (s0),
    .co (c0)
  );

  sqcsa_inc #(.M(N+1)) u_inc (
    .din  ({c0, s0}),
    .dout (inc_q)
  );

  assign sum  = sel ? inc_q[N-1:0] : s0;
  assign cout = sel ? inc_q[N]     : c0;

  // R6
  always_comb begin
    sel_path_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (N+1)'(sel)))
      else $error("group select result mismatch");
  end

endmodule

// File: rtl/sqcsa_adder.sv
module sqcsa_adder
  import sqcsa_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NG = grp_count(WIDTH);
  localparam int W0 = grp_width(WIDTH, 0);

  // carry into each group; the last entry is the adder carry-out
  logic [NG:0] gc;

  assign gc[0] = cin;

  sqcsa_rca #(.N(W0)) u_grp0 (
    .x  (a[W0-1:0]),
    .y  (b[W0-1:0]),
    .ci (gc[0]),
    .s  (sum[W0-1:0]),
    .co (gc[1])
  );

  for (genvar g = 1; g < NG; g++) begin : g_grp
    localparam int GW  = grp_width(WIDTH, g);
    localparam int OFF = grp_offset(WIDTH, g);

    sqcsa_group #(.N(GW)) u_grp (
      .a    (a[OFF +: GW]),
      .b    (b[OFF +: GW]),
      .sel  (gc[g]),
      .sum  (sum[OFF +: GW]),
      .cout (gc[g+1])
    );
  end

  assign cout = gc[NG];

  // R8
  initial begin
    width_table_chk: assert ((WIDTH == 32 || WIDTH == 64 || WIDTH == 128)
                             && grp_total(WIDTH) == WIDTH)
      else $error("group table does not match WIDTH");
  end

  // R1
  always_comb begin
    total_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin)))
      else $error("adder total mismatch");
  end

endmodule

// File: tb/sqcsa_adder_tb.sv
module sqcsa_adder_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] a32, b32, s32;
  logic        c32, co32;
  logic [63:0] a64, b64, s64;
  logic        c64, co64;

  sqcsa_adder #(.WIDTH(32)) u_dut (
    .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32)
  );

  sqcsa_adder #(.WIDTH(64)) u_dut64 (
    .a(a64), .b(b64), .cin(c64), .sum(s64), .cout(co64)
  );

  task automatic chk32(input logic [31:0] x, input logic [31:0] y,
                       input logic c, input string tag);
    logic [32:0] exp;
    @(posedge clk);
    a32 = x; b32 = y; c32 = c;
    exp = {1'b0, x} + {1'b0, y} + 33'(c);
    @(negedge clk);
    checks++;
    if ({co32, s32} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h",
               tag, x, y, c, {co32, s32}, exp);
    end
  endtask

  task automatic chk64(input logic [63:0] x, input logic [63:0] y,
                       input logic c, input string tag);
    logic [64:0] exp;
    @(posedge clk);
    a64 = x; b64 = y; c64 = c;
    exp = {1'b0, x} + {1'b0, y} + 65'(c);
    @(negedge clk);
    checks++;
    if ({co64, s64} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h",
               tag, x, y, c, {co64, s64}, exp);
    end
  endtask

  initial begin
    int bnd32[6] = '{2, 4, 7, 11, 17, 24};
    int bnd64[9] = '{2, 4, 7, 11, 17, 24, 32, 41, 52};
    a32 = '0; b32 = '0; c32 = 1'b0;
    a64 = '0; b64 = '0; c64 = 1'b0;

    // R1 idle state: zero in, zero out
    chk32(32'h0, 32'h0, 1'b0, "R1 zero");
    chk64(64'h0, 64'h0, 1'b0, "R1 zero64");

    // R4 group 0 with external carry, and its carry into group 1
    chk32(32'h0, 32'h0, 1'b1, "R4 cin only");
    chk32(32'h3, 32'h0, 1'b1, "R4 group0 carry out");
    chk32(32'h2, 32'h1, 1'b0, "R4 group0 no carry");

    // R9 full propagate chains
    chk32(32'hFFFF_FFFF, 32'h0, 1'b1, "R9 chain cin");
    chk32(32'hFFFF_FFFF, 32'h1, 1'b0, "R9 chain b");
    chk64(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, "R9 chain64");
    chk32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R9 all ones");

    // R2 R7 carries that stop at and cross each group start (32-bit)
    foreach (bnd32[i]) begin
      logic [31:0] lo;
      lo = (32'(1) << bnd32[i]) - 32'(1);
      chk32(lo, 32'h0, 1'b1, "R2 carry into group start");
      chk32(lo, 32'h1, 1'b0, "R7 carry via b");
      chk32(lo >> 1, lo >> 1, 1'b1, "R2 generate below start");
    end

    // R5 R6 group of ones with incoming carry 0 and 1 (bits 10:7)
    chk32(32'h0000_0780, 32'h0, 1'b0, "R6 select zero-carry");
    chk32(32'h0000_07FF, 32'h0, 1'b1, "R5 converter wraps group");
    chk32(32'h0000_0400, 32'h0000_0400, 1'b0, "R6 group generates carry");
    chk32(32'h00FE_0000, 32'h0001_FFFF, 1'b1, "R5 converter top group below");

    // R3 64-bit boundaries
    foreach (bnd64[i]) begin
      logic [63:0] lo;
      lo = (64'(1) << bnd64[i]) - 64'(1);
      chk64(lo, 64'h0, 1'b1, "R3 carry into group start");
      chk64(lo, 64'h1, 1'b0, "R3 carry via b");
    end

    // R1 R3 random operands
    for (int n = 0; n < 2000; n++)
      chk32($urandom, $urandom, 1'($urandom), "R1 random");
    for (int n = 0; n < 2000; n++)
      chk64({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R3 random");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1: watchdog expired got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule